// File: doc/BRIEF.md
# Dual First-Order Sigma-Delta DAC Modulator

This block turns two 16-bit digital codes into two 1-bit pulse-density streams. Each stream is meant to drive an external RC low-pass filter, which turns it into an analog voltage. Each channel keeps a 16-bit phase accumulator. On every PWM clock the channel adds its code to the accumulator, and the adder's carry-out becomes the next output bit. The high pulses are therefore spread as evenly as the code allows, rather than grouped into one long pulse per frame. Over any 65536 PWM clocks, a channel is high for exactly as many clocks as its code.

The logic runs on a base clock at twice the PWM rate. A PWM clock enable, `pwm_ce`, comes from outside the block and is normally asserted on every other base cycle. A mode input picks the output shaping:
- **Non-return-to-zero:** the output bit is held for the whole PWM clock.
- **Return-to-zero:** a high bit is driven only in the first half of the PWM clock.

Codes are written one byte at a time through a simple write port. The low byte waits in a shadow register. The working code changes only when the high byte is written, so the modulator never sees a half-updated code.

Top module: `sd_dual_dac`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both outputs are low. Reset clears every accumulator, every code and every shadow byte to zero.
- R2: On each base cycle with `pwm_ce` high, each channel computes acc + code. The carry out of bit 15 becomes that channel's output bit, and the low 16 bits become the new accumulator. The output bit is visible from the following base cycle.
- R3: If a code has its low k bits at zero, the output is high on exactly code >> k PWM clocks in any window of 2^(16-k) PWM clocks. For example, 0x4010 gives 1025 highs in 4096 clocks, and 0x1100 gives 17 highs in 256 clocks.
- R4: Starting from a cleared accumulator, code 0x4000 gives one high PWM clock in every four, and code 0xC000 gives three high PWM clocks in every four.
- R5: With `mode_rz` = 0 (non-return-to-zero), the output equals the channel's current bit and does not change on a base cycle that follows a cycle without `pwm_ce`.
- R6: With `mode_rz` = 1 (return-to-zero), the output is high only on the base cycle right after a `pwm_ce` cycle, and only if the channel's bit is 1. On all other base cycles the output is low.
- R7: A write with `wr_hi` = 0 only stores `wr_data` as the low byte of the shadow register for channel `wr_ch`. It does not change the code in use. A write with `wr_hi` = 1 loads the code in use with {`wr_data`, shadow low byte}.
- R8: The two channels share `pwm_ce` and `mode_rz` but are otherwise independent. A write addressed to one channel (`wr_ch` = 0 or 1) never changes the other channel's output sequence.
- R9: On a base cycle with `pwm_ce` low, no accumulator or output bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock, twice the PWM rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_ce | input | 1 | PWM clock enable, normally high every other base cycle |
| mode_rz | input | 1 | Output shaping: 0 = non-return-to-zero, 1 = return-to-zero |
| wr_en | input | 1 | Byte write strobe |
| wr_ch | input | 1 | Channel addressed by the write |
| wr_hi | input | 1 | Byte select: 1 = high byte (commits the code), 0 = low byte (shadow only) |
| wr_data | input | 8 | Byte being written |
| dac_out | output | 2 | One pulse-density output per channel |

## Verification
The bench builds the block with its default parameters: a 16-bit code and two channels. With these values the fixed patterns for 0x4000, 0xC000 and 0x4010 can be checked directly. The 4096-clock and 256-clock repetition windows also fit inside the run, so exact high counts can be compared over whole windows. A full 65536-clock window does not fit in the run. Instead, every PWM clock is checked against an integer model of the accumulator, which covers the same carry behaviour.

// File: rtl/sd_dac_pkg.sv
package sd_dac_pkg;

  typedef enum logic {
    SHAPE_NRZ = 1'b0,
    SHAPE_RZ  = 1'b1
  } shape_e;

endpackage

// File: rtl/sd_code_reg.sv
module sd_code_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [WIDTH/2-1:0] data,
  output logic [WIDTH-1:0] code
);
  localparam int HALF = WIDTH / 2;

  logic [HALF-1:0] lo_shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_shadow_q <= '0;
      code        <= '0;
    end else begin
      if (ld_lo) lo_shadow_q <= data;
      if (ld_hi) code        <= {data, lo_shadow_q};
    end
  end

endmodule

// File: rtl/sd_accum.sv
module sd_accum #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [WIDTH-1:0] code,
  output logic             carry,
  output logic             bit_q
);

  function automatic logic [WIDTH:0] sd_add(input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [WIDTH-1:0] acc_q;
  logic [WIDTH:0]   sum;

  assign sum   = sd_add(acc_q, code);
  assign carry = sum[WIDTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else if (ce) begin
      acc_q <= sum[WIDTH-1:0];
      bit_q <= carry;
    end
  end

endmodule

// File: rtl/sd_shaper.sv
module sd_shaper
  import sd_dac_pkg::*;
(
  input  shape_e mode,
  input  logic   first_half,
  input  logic   bit_in,
  output logic   out
);

  always_comb begin
    unique case (mode)
      SHAPE_RZ:  out = bit_in & first_half;
      default:   out = bit_in;
    endcase
  end

endmodule

// File: rtl/sd_dual_dac.sv
module sd_dual_dac
  import sd_dac_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int NCH   = 2,
  localparam int HALF = WIDTH / 2,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_ce,
  input  logic            mode_rz,
  input  logic            wr_en,
  input  logic [CHW-1:0]  wr_ch,
  input  logic            wr_hi,
  input  logic [HALF-1:0] wr_data,
  output logic [NCH-1:0]  dac_out
);

  logic [NCH*WIDTH-1:0] code_vec;
  logic [NCH-1:0]       carry_vec;
  logic [NCH-1:0]       chan_bit;
  logic                 half_q;
  shape_e               shape;

  assign shape = shape_e'(mode_rz);

  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= pwm_ce;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = wr_en && (wr_ch == CHW'(g));

    sd_code_reg #(.WIDTH(WIDTH)) u_code (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_lo (sel && !wr_hi),
      .ld_hi (sel && wr_hi),
      .data  (wr_data),
      .code  (code_vec[g*WIDTH +: WIDTH])
    );

    sd_accum #(.WIDTH(WIDTH)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (pwm_ce),
      .code  (code_vec[g*WIDTH +: WIDTH]),
      .carry (carry_vec[g]),
      .bit_q (chan_bit[g])
    );

    sd_shaper u_shape (
      .mode       (shape),
      .first_half (half_q),
      .bit_in     (chan_bit[g]),
      .out        (dac_out[g])
    );
  end

endmodule

// File: rtl/sd_dual_dac_chk.sv
module sd_dual_dac_chk #(
  parameter int WIDTH = 16,
  parameter int NCH   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pwm_ce,
  input logic                 mode_rz,
  input logic                 wr_en,
  input logic                 wr_hi,
  input logic [NCH-1:0]       dac_out,
  input logic [NCH-1:0]       chan_bit,
  input logic [NCH-1:0]       carry_vec,
  input logic [NCH*WIDTH-1:0] code_vec
);

  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> dac_out == '0);

  p_carry_to_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_ce |=> chan_bit == $past(carry_vec));

  p_nrz_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rz && !$past(mode_rz) && !$past(pwm_ce)) |-> $stable(dac_out));

  p_rz_late_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rz && !$past(pwm_ce)) |-> dac_out == '0);

  p_low_write_keeps_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> $stable(code_vec));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_ce |=> $stable(chan_bit));

endmodule

bind sd_dual_dac sd_dual_dac_chk #(.WIDTH(WIDTH), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_ce    (pwm_ce),
  .mode_rz   (mode_rz),
  .wr_en     (wr_en),
  .wr_hi     (wr_hi),
  .dac_out   (dac_out),
  .chan_bit  (chan_bit),
  .carry_vec (carry_vec),
  .code_vec  (code_vec)
);

// File: tb/sd_dual_dac_test.sv
`timescale 1ns/1ps
module sd_dual_dac_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_ce = 1'b0;
  logic       mode_rz = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_ch = '0;
  logic       wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] dac_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int acc_m[2];
  int code_m[2];
  int shadow_m[2];
  bit bit_m[2];
  bit half_m;
  int highs[2];

  always #4 clk = ~clk;

  sd_dual_dac uut (
    .clk(clk), .rst_n(rst_n), .pwm_ce(pwm_ce), .mode_rz(mode_rz),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_hi(wr_hi), .wr_data(wr_data),
    .dac_out(dac_out)
  );

  function automatic bit model_out(input int c);
    if (mode_rz) return bit_m[c] && half_m;
    return bit_m[c];
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      acc_m[c] = 0; code_m[c] = 0; shadow_m[c] = 0; bit_m[c] = 0;
    end
    half_m = 0;
  endtask

  // drive at negedge, model the edge, compare at the next negedge
  task automatic step(input bit ce, input bit we, input int ch, input bit hi,
                      input int data, input string req);
    pwm_ce = ce; wr_en = we; wr_ch = ch[0]; wr_hi = hi; wr_data = data[7:0];
    @(posedge clk);
    if (ce) begin
      for (int c = 0; c < 2; c++) begin
        int s;
        s = acc_m[c] + code_m[c];
        bit_m[c] = (s >= 65536);
        acc_m[c] = s % 65536;
      end
    end
    half_m = ce;
    if (we) begin
      if (hi) code_m[ch] = (data * 256) + shadow_m[ch];
      else    shadow_m[ch] = data;
    end
    @(negedge clk);
    pwm_ce = 0; wr_en = 0;
    for (int c = 0; c < 2; c++) check(req, dac_out[c], model_out(c));
  endtask

  task automatic write_code(input int ch, input int code, input string req);
    step(0, 1, ch, 0, code % 256, req);
    step(0, 1, ch, 1, code / 256, req);
  endtask

  // n PWM clocks, counting highs on the first half of each
  task automatic run_pwm(input int n, input string req);
    highs[0] = 0; highs[1] = 0;
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0, 0, 0, req);
      highs[0] += dac_out[0];
      highs[1] += dac_out[1];
      step(0, 0, 0, 0, 0, req);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    model_reset();
    check("R1 reset low", dac_out, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", dac_out, 0);
  endtask

  initial begin
    void'($urandom(32'h5D1A_0C3E));
    @(negedge clk);
    do_reset();

    // R4 / R2: quarter and three-quarter codes from cleared accumulators
    write_code(0, 16'h4000, "R7 write");
    write_code(1, 16'hC000, "R8 write");
    run_pwm(16, "R2 quarter patterns");
    check("R4 ch0 0x4000 highs in 16", highs[0], 4);
    check("R4 ch1 0xC000 highs in 16", highs[1], 12);

    // R3: repetition windows
    write_code(0, 16'h4010, "R7 write");
    write_code(1, 16'h1100, "R8 write");
    run_pwm(4096, "R2 window run");
    check("R3 ch0 0x4010 highs in 4096", highs[0], 1025);
    check("R3 ch1 0x1100 highs in 4096", highs[1], 272);
    run_pwm(256, "R2 short window");
    check("R3 ch1 0x1100 highs in 256", highs[1], 17);

    // R6: return-to-zero shaping
    mode_rz = 1;
    run_pwm(64, "R6 rz shaping");
    check("R6 rz ch0 highs in 64", highs[0] >= 16 ? 1 : 0, 1);
    mode_rz = 0;

    // R7: low byte alone leaves the code in use alone
    step(0, 1, 0, 0, 8'hFF, "R7 low byte only");
    run_pwm(32, "R7 old code still in use");
    step(0, 1, 1, 1, 8'h00, "R8 hi write ch1");
    run_pwm(32, "R8 ch0 unaffected");

    // R9: enable idle holds everything
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, "R9 idle hold");
    run_pwm(8, "R9 resume");

    // R5: full-scale and zero corner codes
    write_code(0, 16'hFFFF, "R7 write");
    write_code(1, 16'h0000, "R8 write");
    run_pwm(64, "R5 nrz corners");
    check("R5 ch1 zero code highs", highs[1], 0);
    check("R5 ch0 near-full highs", highs[0] >= 63 ? 1 : 0, 1);

    // random mix
    begin
      bit prev = 0;
      for (int i = 0; i < 6000; i++) begin
        bit ce, we;
        ce = prev ? 1'b0 : (($urandom % 8) != 0);
        we = ($urandom % 16) == 0;
        if (($urandom % 512) == 0) mode_rz = ~mode_rz;
        step(ce, we, $urandom % 2, $urandom % 2, $urandom % 256, "R2 random");
        prev = ce;
      end
    end

    do_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule